// File: doc/BRIEF.md
# Half to Single Precision Widening Converter

This block turns a 16-bit IEEE-754 half-precision encoding into the 32-bit single-precision encoding of the same value. Every half value, subnormals included, fits exactly in single precision, so no rounding is involved. The input is sorted into one of five classes: zero, subnormal, normal, infinity or NaN. Each class has its own result path. Subnormal halves are renormalised: a leading-zero count sets both the shift that hides the first set mantissa bit and the exponent correction.

NaN inputs are handled in one of two ways, chosen per operation by a mode input. Either the sign and payload are kept and the quiet bit is forced on, or the result is replaced by a single fixed default NaN. A signalling NaN input raises an invalid-operation pulse in either mode.

The converter is a single registered stage with a valid/ready handshake on both sides. A result appears one cycle after it is accepted. The stage holds its result for as long as the consumer stalls.

Top module: `hcvt_widen`

## Requirements
- R1: A half input whose exponent field (bits 14:10) and mantissa field (bits 9:0) are both zero gives a single zero with the same sign, bit 31 equal to input bit 15.
- R2: An input with exponent 31 and mantissa 0 gives 0x7F800000 when bit 15 is 0 and 0xFF800000 when bit 15 is 1.
- R3: For a normal input (exponent from 1 to 30), the result has the same sign and an exponent equal to the input exponent plus 112. Its 23-bit fraction is the 10 input mantissa bits followed by 13 zero bits.
- R4: For a subnormal input (exponent 0, mantissa nonzero with L leading zeros within its 10 bits), the result has the same sign and exponent 112 − L. Its fraction is the mantissa shifted left by L+1, kept to 10 bits, and followed by 13 zeros.
- R5: When the default-NaN mode is 0, a NaN input (exponent 31, mantissa nonzero) gives the input sign, exponent 255, fraction bit 22 set, fraction bits 21:13 equal to input mantissa bits 8:0, and fraction bits 12:0 zero.
- R6: When the default-NaN mode is 1, every NaN input gives 0x7FC00000, whatever its sign or payload. The mode has no effect on non-NaN inputs.
- R7: The invalid flag is high with a result exactly when that result came from a NaN whose mantissa bit 9 is 0, in either mode. It is low for all other inputs.
- R8: An input accepted on a clock edge (input valid and ready both high) shows as output valid, with its result, from that edge until the edge on which the output is taken.
- R9: While the output is valid and the output ready is low, the result and the flag do not change, and input ready is low.
- R10: After reset, output valid and the invalid flag are low and input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input operand present |
| in_ready | output | 1 | Stage can take an operand this cycle |
| in_half | input | 16 | Half-precision encoding |
| dflt_nan_en | input | 1 | 1: NaN inputs give the fixed default NaN |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_single | output | 32 | Single-precision encoding |
| out_invalid | output | 1 | Signalling NaN seen, pulse aligned with the result |

## Verification
Any mistake in classification, the leading-zero count or the rebias gives a wrong output word in the cycle after acceptance. All 65536 encodings are swept in both NaN modes, so each class path is compared word for word against an arithmetic model. A model that normalises by repeated doubling checks the subnormal path without using a leading-zero count. A corrupted handshake state shows at the ports as a result that changes or drops while stalled, or as in_ready staying high with the output full. A directed stall sequence checks for both, and bound properties cover them on every cycle.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;
    localparam int HALF_EXP_W = 5;
    localparam int HALF_MAN_W = 10;
    localparam int HALF_W     = 1 + HALF_EXP_W + HALF_MAN_W;
    localparam int SGL_EXP_W  = 8;
    localparam int SGL_MAN_W  = 23;
    localparam int SGL_W      = 1 + SGL_EXP_W + SGL_MAN_W;
    localparam int MAN_PAD    = SGL_MAN_W - HALF_MAN_W;
    localparam int BIAS_ADJ   = ((1 << (SGL_EXP_W - 1)) - 1) - ((1 << (HALF_EXP_W - 1)) - 1);
    localparam int LZ_W       = $clog2(HALF_MAN_W + 1);

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } fp_class_e;

    typedef struct packed {
        logic             vld;
        logic             inv;
        logic [SGL_W-1:0] res;
    } stage_t;
endpackage

// File: rtl/hcvt_classify.sv
module hcvt_classify
    import hcvt_pkg::*;
(
    input  logic [HALF_W-1:0]     half_i,
    output logic                  sign_o,
    output logic [HALF_EXP_W-1:0] exp_o,
    output logic [HALF_MAN_W-1:0] man_o,
    output fp_class_e             cls_o
);
    logic exp_zero;
    logic exp_ones;
    logic man_zero;

    always_comb begin
        sign_o   = half_i[HALF_W-1];
        exp_o    = half_i[HALF_W-2 -: HALF_EXP_W];
        man_o    = half_i[HALF_MAN_W-1:0];
        exp_zero = (exp_o == '0);
        exp_ones = (exp_o == '1);
        man_zero = (man_o == '0);
        if (exp_zero)      cls_o = man_zero ? CLS_ZERO : CLS_SUB;
        else if (exp_ones) cls_o = man_zero ? CLS_INF : CLS_NAN;
        else               cls_o = CLS_NORM;
    end
endmodule

// File: rtl/hcvt_lzc.sv
module hcvt_lzc #(
    parameter int W = 10,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        cnt_o = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) cnt_o = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/hcvt_pack.sv
module hcvt_pack
    import hcvt_pkg::*;
(
    input  fp_class_e             cls_i,
    input  logic                  sign_i,
    input  logic [HALF_EXP_W-1:0] exp_i,
    input  logic [HALF_MAN_W-1:0] man_i,
    input  logic [LZ_W-1:0]       lz_i,
    input  logic                  dn_i,
    output logic [SGL_W-1:0]      res_o,
    output logic                  inv_o
);
    logic [2*HALF_MAN_W:0] sub_wide;
    logic [HALF_MAN_W-1:0] sub_frac;
    logic [SGL_EXP_W-1:0]  sub_exp;
    logic [SGL_EXP_W-1:0]  norm_exp;

    always_comb begin
        sub_wide = {{(HALF_MAN_W+1){1'b0}}, man_i} << (lz_i + 1'b1);
        sub_frac = sub_wide[HALF_MAN_W-1:0];
        sub_exp  = SGL_EXP_W'(BIAS_ADJ) - SGL_EXP_W'(lz_i);
        norm_exp = SGL_EXP_W'(exp_i) + SGL_EXP_W'(BIAS_ADJ);
        inv_o    = (cls_i == CLS_NAN) && !man_i[HALF_MAN_W-1];
        unique case (cls_i)
            CLS_ZERO: res_o = {sign_i, {(SGL_W-1){1'b0}}};
            CLS_INF:  res_o = {sign_i, {SGL_EXP_W{1'b1}}, {SGL_MAN_W{1'b0}}};
            CLS_NORM: res_o = {sign_i, norm_exp, man_i, {MAN_PAD{1'b0}}};
            CLS_SUB:  res_o = {sign_i, sub_exp, sub_frac, {MAN_PAD{1'b0}}};
            default: begin
                if (dn_i) res_o = {1'b0, {SGL_EXP_W{1'b1}}, 1'b1, {(SGL_MAN_W-1){1'b0}}};
                else      res_o = {sign_i, {SGL_EXP_W{1'b1}}, 1'b1,
                                   man_i[HALF_MAN_W-2:0], {MAN_PAD{1'b0}}};
            end
        endcase
    end
endmodule

// File: rtl/hcvt_widen.sv
module hcvt_widen
    import hcvt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [HALF_W-1:0] in_half,
    input  logic              dflt_nan_en,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SGL_W-1:0]  out_single,
    output logic              out_invalid
);
    logic                  sign_c;
    logic [HALF_EXP_W-1:0] exp_c;
    logic [HALF_MAN_W-1:0] man_c;
    fp_class_e             cls_c;
    logic [LZ_W-1:0]       lz_c;
    logic [SGL_W-1:0]      res_c;
    logic                  inv_c;
    stage_t                st_d, st_q;

    hcvt_classify u_cls (
        .half_i (in_half),
        .sign_o (sign_c),
        .exp_o  (exp_c),
        .man_o  (man_c),
        .cls_o  (cls_c)
    );

    hcvt_lzc #(.W(HALF_MAN_W)) u_lzc (
        .vec_i (man_c),
        .cnt_o (lz_c)
    );

    hcvt_pack u_pack (
        .cls_i  (cls_c),
        .sign_i (sign_c),
        .exp_i  (exp_c),
        .man_i  (man_c),
        .lz_i   (lz_c),
        .dn_i   (dflt_nan_en),
        .res_o  (res_c),
        .inv_o  (inv_c)
    );

    assign in_ready    = !st_q.vld || out_ready;
    assign out_valid   = st_q.vld;
    assign out_single  = st_q.res;
    assign out_invalid = st_q.vld && st_q.inv;

    always_comb begin
        st_d = st_q;
        if (in_ready) begin
            st_d.vld = in_valid;
            st_d.inv = in_valid && inv_c;
            if (in_valid) st_d.res = res_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hcvt_widen_chk.sv
module hcvt_widen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [15:0] in_half,
    input logic        dflt_nan_en,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_single,
    input logic        out_invalid
);
    logic in_nan;
    logic in_norm;
    assign in_nan  = (in_half[14:10] == 5'h1F) && (in_half[9:0] != 10'h0);
    assign in_norm = (in_half[14:10] != 5'h00) && (in_half[14:10] != 5'h1F);

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_single) && $stable(out_invalid));

    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    a_r6_default_nan: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && dflt_nan_en && in_nan |=> out_single == 32'h7FC00000);

    a_r7_flag_is_nan: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> out_valid && out_single[30:23] == 8'hFF && out_single[22]);

    a_r3_rebias: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_norm |=>
        out_single[30:23] == 8'($past(in_half[14:10])) + 8'd112);

    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_invalid && in_ready);
endmodule

bind hcvt_widen hcvt_widen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_half     (in_half),
    .dflt_nan_en (dflt_nan_en),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_single  (out_single),
    .out_invalid (out_invalid)
);

// File: tb/hcvt_widen_test.sv
module hcvt_widen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 180000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_half = '0;
    logic        dflt_nan_en = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_single;
    logic        out_invalid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    hcvt_widen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_half(in_half), .dflt_nan_en(dflt_nan_en), .out_valid(out_valid),
        .out_ready(out_ready), .out_single(out_single), .out_invalid(out_invalid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Arithmetic model: {invalid, result}
    function automatic logic [32:0] model(input logic [15:0] h, input logic dn);
        logic        s;
        int          e, m, steps;
        logic [31:0] r;
        logic        inv;
        s = h[15]; e = int'(h[14:10]); m = int'(h[9:0]);
        inv = 1'b0;
        if (e == 0 && m == 0) r = {s, 31'h0};
        else if (e == 31 && m == 0) r = s ? 32'hFF800000 : 32'h7F800000;
        else if (e == 31) begin
            inv = (m < 512);
            if (dn) r = 32'h7FC00000;
            else    r = {s, 8'hFF, 1'b1, 9'(m % 512), 13'h0};
        end else if (e == 0) begin
            steps = 0;
            while (m < 1024) begin m = m * 2; steps++; end
            r = {s, 8'(113 - steps), 10'(m - 1024), 13'h0};
        end else r = {s, 8'(e + 112), 10'(m), 13'h0};
        return {inv, r};
    endfunction

    function automatic string req_of(input logic [15:0] h, input logic dn);
        if (h[14:10] == 0)  return (h[9:0] == 0) ? "R1" : "R4";
        if (h[14:10] == 31) return (h[9:0] == 0) ? "R2" : (dn ? "R6/R7" : "R5/R7");
        return dn ? "R3/R6" : "R3";
    endfunction

    task automatic check_out(input string req, input logic [15:0] h, input logic [32:0] exp_v);
        checks++;
        if (!out_valid || out_single !== exp_v[31:0] || out_invalid !== exp_v[32]) begin
            errors++;
            $display("FAIL %s in=%h: valid=%b res=%h inv=%b expected valid=1 res=%h inv=%b",
                     req, h, out_valid, out_single, out_invalid, exp_v[31:0], exp_v[32]);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp_b, input string what);
        checks++;
        if (act !== exp_b) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp_b);
        end
    endtask

    task automatic sweep(input logic dn);
        logic [15:0] prev;
        bit          have = 0;
        dflt_nan_en = dn;
        for (int i = 0; i < 65536; i++) begin
            @(negedge clk);
            if (have) check_out(req_of(prev, dn), prev, model(prev, dn));
            in_valid = 1'b1;
            in_half  = 16'(i);
            prev     = 16'(i);
            have     = 1;
        end
        @(negedge clk);
        check_out(req_of(prev, dn), prev, model(prev, dn));
        in_valid = 1'b0;
        @(negedge clk);
        check_bit("R8", out_valid, 1'b0, "out_valid after drain");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check_bit("R10", out_valid, 1'b0, "out_valid in reset");
        check_bit("R10", out_invalid, 1'b0, "out_invalid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R10", in_ready, 1'b1, "in_ready after reset");
        check_bit("R10", out_valid, 1'b0, "out_valid after reset");

        sweep(1'b0);
        sweep(1'b1);

        // R8/R9: stall with a signalling NaN held in the stage
        dflt_nan_en = 1'b0;
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_half   = 16'h7C01;
        @(negedge clk);
        check_out("R8", 16'h7C01, model(16'h7C01, 1'b0));
        check_bit("R9", in_ready, 1'b0, "in_ready while stalled");
        in_half = 16'hC000;
        @(negedge clk);
        check_out("R9", 16'h7C01, model(16'h7C01, 1'b0));
        @(negedge clk);
        check_out("R9", 16'h7C01, model(16'h7C01, 1'b0));
        out_ready = 1'b1;
        @(negedge clk);
        check_out("R8", 16'hC000, model(16'hC000, 1'b0));
        in_valid = 1'b0;
        @(negedge clk);
        check_bit("R7", out_invalid, 1'b0, "flag after drain");
        check_bit("R8", out_valid, 1'b0, "out_valid after drain");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule